// File: doc/BRIEF.md
# Synchronizing Debouncer with Edge Strobes

This block cleans up a single noisy, asynchronous input bit, such as a push button or a mechanical switch, for use inside one clock domain. The raw pin first passes through a chain of flip-flops that brings it into the clock domain. A stability filter then accepts a new level only after the synchronized value has disagreed with the current clean level for a set number of consecutive cycles. Any excursion shorter than that count is discarded.

The clean level is presented as a registered output. Two registered strobes come with it: one pulses for a single cycle when the clean level goes from 0 to 1, and the other pulses for a single cycle when it goes from 1 to 0. Both strobes line up with the cycle in which the level flips. The synchronizer depth (`SYNC_STAGES`, default 2) and the wait count (`WAIT_CYCLES`, default 3) are parameters. As a sizing example, a wait count of 10 with a 50 MHz clock rejects pulses up to roughly 200 ns.

Top module: `pin_conditioner`

## Requirements
- R1: The raw pin goes through a `SYNC_STAGES`-deep flip-flop synchronizer before any filtering, and that depth adds to the output latency.
- R2: `level_out` takes a new value only after the synchronized input has differed from it for `WAIT_CYCLES` consecutive cycles. A pin pulse held for `WAIT_CYCLES` cycles gets through, and one held for `WAIT_CYCLES`-1 cycles does not.
- R3: After the pin changes and then stays steady, `level_out` follows exactly `SYNC_STAGES`+`WAIT_CYCLES` rising clock edges after the first edge that samples the new pin value. With the defaults this is 5 edges, in both directions.
- R4: Bounces are suppressed in both directions. A burst of runs that are each shorter than the wait count produces no strobe, and `rise_pulse` and `fall_pulse` are never high together.
- R5: `rise_pulse` is high for exactly one cycle each time `level_out` goes from 0 to 1, and at no other time.
- R6: `fall_pulse` is high for exactly one cycle each time `level_out` goes from 1 to 0, and at no other time.
- R7: A strobe is high in the same cycle in which `level_out` shows its new value.
- R8: While `rst` is high (synchronous, active high), `level_out`, both strobes, the synchronizer and the stability counter are cleared to 0. After reset is released with the pin held high, the full latency from R3 applies again.
- R9: If the synchronized input returns to the current level partway through a count, the count restarts from zero. Two short runs in the same direction therefore do not add up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register in the block |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | 1 | Noisy asynchronous input bit |
| level_out | output | 1 | Debounced level, registered |
| rise_pulse | output | 1 | One-cycle strobe on a 0-to-1 change of `level_out` |
| fall_pulse | output | 1 | One-cycle strobe on a 1-to-0 change of `level_out` |

## Verification
A stability counter left in the wrong state shows up as a latency error. The clean level moves earlier or later than `SYNC_STAGES`+`WAIT_CYCLES` edges after a steady pin change, or a pulse one cycle shorter than the wait count leaks through. A counter that fails to restart makes two short bounces add up to a spurious edge within a few cycles of the second bounce. A wrong strobe register shows on the very next cycle, as a pulse two cycles wide, a pulse with no level change, or a level change with no pulse.

// File: rtl/pin_cond_pkg.sv
package pin_cond_pkg;

  // Request from the stability filter to adopt a new level this cycle.
  typedef struct packed {
    logic fire;
    logic value;
  } commit_t;

  // Counter width able to hold 0 .. n-1, at least one bit.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pc_filter.sv
module pc_filter
  import pin_cond_pkg::*;
#(
  parameter int WAIT = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sample,
  output logic    level,
  output commit_t commit
);

  localparam int            CW   = count_width(WAIT);
  localparam logic [CW-1:0] LAST = CW'(WAIT - 1);

  logic [CW-1:0] run_cnt;
  logic          differ;

  // A run of disagreeing samples reaches its final cycle here.
  always_comb begin
    differ       = sample ^ level;
    commit.fire  = differ && (run_cnt == LAST);
    commit.value = sample;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (!differ) begin
      run_cnt <= '0;
    end else if (commit.fire) begin
      level   <= commit.value;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pc_strobe.sv
module pc_strobe
  import pin_cond_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  commit_t commit,
  output logic    rise,
  output logic    fall
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= commit.fire &  commit.value;
      fall <= commit.fire & ~commit.value;
    end
  end

endmodule

// File: rtl/pin_conditioner.sv
module pin_conditioner
  import pin_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic level_out,
  output logic rise_pulse,
  output logic fall_pulse
);

  logic    synced_bit;
  commit_t commit;

  pc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_raw),
    .q   (synced_bit)
  );

  pc_filter #(.WAIT(WAIT_CYCLES)) u_filter (
    .clk    (clk),
    .rst    (rst),
    .sample (synced_bit),
    .level  (level_out),
    .commit (commit)
  );

  pc_strobe u_strobe (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .rise   (rise_pulse),
    .fall   (fall_pulse)
  );

endmodule

// File: rtl/pin_conditioner_chk.sv
module pin_conditioner_chk #(
  parameter int WAIT_CYCLES = 3
) (
  input logic clk,
  input logic rst,
  input logic level,
  input logic rise,
  input logic fall
);

  // R4: the two strobes are exclusive
  a_r4_no_dual: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));

  // R5: a rise strobe lasts one cycle and marks a 0-to-1 change
  a_r5_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
  a_r5_rise_up: assert property (@(posedge clk) disable iff (rst)
    rise |-> (level && !$past(level)));

  // R6: a fall strobe lasts one cycle and marks a 1-to-0 change
  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
  a_r6_fall_down: assert property (@(posedge clk) disable iff (rst)
    fall |-> (!level && $past(level)));

  // R7: every change of level carries a strobe in the same cycle
  a_r7_flip_strobed: assert property (@(posedge clk) disable iff (rst)
    (level != $past(level)) |-> (rise || fall));

  // R2: with a wait longer than one cycle, two flips are never adjacent
  a_r2_no_adjacent_flip: assert property (@(posedge clk) disable iff (rst)
    ((WAIT_CYCLES > 1) && (level != $past(level))) |=> (level == $past(level)));

endmodule

bind pin_conditioner pin_conditioner_chk #(.WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .level (level_out),
  .rise  (rise_pulse),
  .fall  (fall_pulse)
);

// File: tb/pin_conditioner_bench.sv
`timescale 1ns/1ps
module pin_conditioner_bench;

  localparam int SYNC = 2;
  localparam int WAITC = 3;
  localparam int LAT = SYNC + WAITC;
  localparam int NV = 18;
  // {pin, hold cycles, level at end, rise count, fall count}
  localparam int VEC [NV][5] = '{
    '{1, 8, 1, 1, 0},
    '{0, 2, 1, 0, 0},
    '{1, 8, 1, 0, 0},
    '{0, 8, 0, 0, 1},
    '{1, 1, 0, 0, 0},
    '{0, 1, 0, 0, 0},
    '{1, 2, 0, 0, 0},
    '{0, 1, 0, 0, 0},
    '{1, 8, 1, 1, 0},
    '{0, 1, 1, 0, 0},
    '{1, 1, 1, 0, 0},
    '{0, 2, 1, 0, 0},
    '{1, 1, 1, 0, 0},
    '{0, 8, 0, 0, 1},
    '{1, 3, 0, 0, 0},
    '{0, 8, 0, 1, 1},
    '{1, 2, 0, 0, 0},
    '{0, 8, 0, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic level, rise, fall;

  int tests = 0;
  int fails = 0;
  logic prev_level = 1'b0, prev_rise = 1'b0, prev_fall = 1'b0;
  int seen_rise = 0, seen_fall = 0;

  always #2 clk = ~clk;

  pin_conditioner #(.SYNC_STAGES(SYNC), .WAIT_CYCLES(WAITC)) u_pin_conditioner (
    .clk        (clk),
    .rst        (rst),
    .pin_raw    (pin),
    .level_out  (level),
    .rise_pulse (rise),
    .fall_pulse (fall)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive pin, let one rising edge pass, sample at the falling edge.
  task automatic step(input logic p);
    pin = p;
    @(posedge clk);
    @(negedge clk);
    seen_rise += int'(rise);
    seen_fall += int'(fall);
    if (!rst) begin
      if (level != prev_level)
        chk((rise == level) && (fall == !level), "R7 strobe with flip",
            int'({rise, fall}), int'({level, !level}));
      if (rise) chk(!prev_rise, "R5 rise width", 2, 1);
      if (fall) chk(!prev_fall, "R6 fall width", 2, 1);
      if (rise || fall) chk(!(rise && fall), "R4 exclusive strobes", 2, 1);
    end
    prev_level = level;
    prev_rise  = rise;
    prev_fall  = fall;
  endtask

  task automatic measure(input logic p, input string req);
    int n = 0;
    do begin
      step(p);
      n++;
    end while (level != p && n < 20);
    chk(n == LAT, req, n, LAT);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(level == 1'b0, "R8 reset level", int'(level), 0);
    chk(rise == 1'b0 && fall == 1'b0, "R8 reset strobes", int'({rise, fall}), 0);
    rst = 1'b0;

    // Table walk: R2 R4 R5 R6 R9 (glitches, bounces, exact-width pulse)
    for (int v = 0; v < NV; v++) begin
      seen_rise = 0;
      seen_fall = 0;
      for (int c = 0; c < VEC[v][1]; c++) step(logic'(VEC[v][0]));
      chk(int'(level) == VEC[v][2], $sformatf("R2 level vec %0d", v), int'(level), VEC[v][2]);
      chk(seen_rise == VEC[v][3], $sformatf("R5 rise count vec %0d", v), seen_rise, VEC[v][3]);
      chk(seen_fall == VEC[v][4], $sformatf("R6 fall count vec %0d", v), seen_fall, VEC[v][4]);
    end

    // R3 and R1: latency in both directions
    measure(1'b1, "R3 rise latency (R1 sync depth)");
    measure(1'b0, "R3 fall latency (R1 sync depth)");

    // R9: two short runs separated by a return do not add up
    seen_rise = 0;
    step(1'b1); step(1'b1); step(1'b0); step(1'b1); step(1'b1);
    repeat (6) step(1'b0);
    chk(seen_rise == 0 && level == 1'b0, "R9 count restart", seen_rise, 0);

    // R8: reset while high, then full latency again
    measure(1'b1, "R3 rise before reset");
    rst = 1'b1;
    step(1'b1);
    step(1'b1);
    chk(level == 1'b0, "R8 reset clears level", int'(level), 0);
    chk(rise == 1'b0 && fall == 1'b0, "R8 reset clears strobes", int'({rise, fall}), 0);
    rst = 1'b0;
    measure(1'b1, "R8 latency after reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule